// File: doc/BRIEF.md
# Sampling Converter Host Interface Controller

This block is the digital front end that sits between a host bus and the analog core of a sampling 10-bit converter. The host drives three active-low strobes: chip select, sample/hold and read. It also drives a two-bit channel selector. The controller turns these into phase strobes for the conversion core and sequences the conversion with an internal cycle counter, so no external conversion clock is needed. When a conversion ends it latches the core's code into an output register and pulls an active-low interrupt. That register is placed on a data bus, which is enabled only during a selected read.

Two interface styles are supported, chosen by a static mode input. In the first, the host's sample/hold low time marks the sampling window, and the coarse phase closes when sample/hold rises. In the second, sample/hold and read are wired together: a single falling edge starts the conversion, and internal counters time both the sampling window and the coarse phase. Every asynchronous input is passed through a two-flop synchronizer before edges are detected, so each timing figure below includes a fixed three-cycle entry latency. The phase lengths are parameters: S for the sampling window, C for the coarse phase and F for the fine phase. Latencies are counted in rising clock edges after the input changes.

Top module: `adc_bus_ctrl`

## Requirements
- R1: While chip select is high, neither sample/hold nor read has any effect: no conversion starts, the bus enable stays low and the interrupt stays high.
- R2: A conversion starts when chip select and sample/hold are both low. The channel selector is captured at that start and held on the core channel output for the whole conversion. Selector values 0, 1, 2 and 3 select core inputs 0, 1, 2 and 3.
- R3: In the two-input variant (NUM_CH = 2), only bit 0 of the selector is used, and bit 1 of the core channel output is always 0.
- R4: In mode 1 (mode2 = 0), the fine phase starts at whichever comes later: sample/hold rising, or S cycles of sampling. If sample/hold is held low for L edges, the interrupt falls max(S, L) + 3 + F edges after the falling edge.
- R5: In mode 2 (mode2 = 1), the sampling window is timed internally for S cycles and the coarse phase for C cycles. The interrupt falls 3 + S + C + F edges after the falling edge of the combined line.
- R6: The interrupt falls only when a result is latched. It stays low while read is held low, and it returns high within four edges of read rising.
- R7: The bus enable is high only while chip select and read are both low. It returns low after read rises.
- R8: The data output holds the previous result throughout a conversion and changes only in the cycle in which the interrupt falls. It then carries the code the core presented for the captured channel.
- R9: A falling edge of sample/hold during a conversion is ignored: the running conversion keeps its timing and channel. A sticky missed flag is set, and it clears at the next accepted start.
- R10: After reset the interrupt is high, the bus enable is low, the data output is 0 and the missed flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode2 | input | 1 | Static mode select: 0 means sample/hold sets the sampling window, 1 means sample/hold and read are tied together |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| sh_n | input | 1 | Sample/hold strobe, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| chsel | input | 2 | Channel selector, captured when a conversion starts |
| core_code | input | 10 | Conversion code delivered by the analog core |
| core_sample | output | 1 | High while the core's input is being sampled |
| core_coarse_lat | output | 1 | One-cycle strobe: latch the coarse result and begin the fine phase |
| core_result_lat | output | 1 | One-cycle strobe: the full result is latched |
| core_chan | output | 2 | Channel routed to the core for the current conversion |
| irq_n | output | 1 | End-of-conversion interrupt, active low |
| dbus_out | output | 10 | Output result register |
| dbus_oe | output | 1 | Output enable for the tri-state data bus |
| missed | output | 1 | Sticky flag: a start request arrived while a conversion was running |

## Verification
The embedded assertions check, on every cycle, the behaviours that can be seen locally. The interrupt falls only on a result latch and rises only on a read release. The output register never moves except on a latch. The captured channel stays fixed while a conversion is busy. The missed flag rises only when a request arrives during a busy phase. What only the bench scenarios can show are the end-to-end latencies in both modes, including the case where sample/hold rises before the minimum sampling count. The scenarios also cover the correct channel-to-code routing for every selector value in both channel variants, the blocking of every strobe by chip select, and the fact that a request arriving during a conversion leaves its timing unchanged.

// File: rtl/adc_bus_pkg.sv
package adc_bus_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SAMP   = 2'd1,
        PH_COARSE = 2'd2,
        PH_FINE   = 2'd3
    } phase_e;

    localparam int CHAN_W = 2;

endpackage

// File: rtl/adc_sync2.sv
module adc_sync2 #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] meta_q, meta_d;
    logic [W-1:0] hold_q, hold_d;

    always_comb begin
        meta_d = async_in;
        hold_d = meta_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '1;
            hold_q <= '1;
        end else begin
            meta_q <= meta_d;
            hold_q <= hold_d;
        end
    end

    assign sync_out = hold_q;
endmodule

// File: rtl/adc_conv_fsm.sv
module adc_conv_fsm
    import adc_bus_pkg::*;
#(
    parameter int SAMPLE_CYC = 13,
    parameter int COARSE_CYC = 12,
    parameter int FINE_CYC   = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode2,
    input  logic              start,
    input  logic              sh_act,
    input  logic [CHAN_W-1:0] chsel_m,
    output logic              core_sample,
    output logic              coarse_lat,
    output logic              result_lat,
    output logic [CHAN_W-1:0] chan,
    output logic              missed
);
    localparam int MAXC = (SAMPLE_CYC > COARSE_CYC)
                        ? ((SAMPLE_CYC > FINE_CYC) ? SAMPLE_CYC : FINE_CYC)
                        : ((COARSE_CYC > FINE_CYC) ? COARSE_CYC : FINE_CYC);
    localparam int CNTW = $clog2(MAXC + 1);
    localparam logic [CNTW-1:0] S_END = CNTW'(SAMPLE_CYC - 1);
    localparam logic [CNTW-1:0] C_END = CNTW'(COARSE_CYC - 1);
    localparam logic [CNTW-1:0] F_END = CNTW'(FINE_CYC - 1);

    typedef struct packed {
        phase_e            phase;
        logic [CNTW-1:0]   cnt;
        logic [CHAN_W-1:0] chan;
        logic              missed;
    } fsm_t;

    fsm_t q, d;

    always_comb begin
        d          = q;
        coarse_lat = 1'b0;
        result_lat = 1'b0;
        case (q.phase)
            PH_IDLE: begin
                if (start) begin
                    d.phase  = PH_SAMP;
                    d.cnt    = '0;
                    d.chan   = chsel_m;
                    d.missed = 1'b0;
                end
            end
            PH_SAMP: begin
                if (q.cnt == S_END) begin
                    if (mode2) begin
                        d.phase = PH_COARSE;
                        d.cnt   = '0;
                    end else if (!sh_act) begin
                        coarse_lat = 1'b1;
                        d.phase    = PH_FINE;
                        d.cnt      = '0;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            PH_COARSE: begin
                if (q.cnt == C_END) begin
                    coarse_lat = 1'b1;
                    d.phase    = PH_FINE;
                    d.cnt      = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: begin
                if (q.cnt == F_END) begin
                    result_lat = 1'b1;
                    d.phase    = PH_IDLE;
                    d.cnt      = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
        endcase
        if (start && q.phase != PH_IDLE) begin
            d.missed = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{phase: PH_IDLE, cnt: '0, chan: '0, missed: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign core_sample = (q.phase == PH_SAMP);
    assign chan        = q.chan;
    assign missed      = q.missed;

    AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({coarse_lat, result_lat, start && q.phase == PH_IDLE})); // R4
    AST_CHAN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase != PH_IDLE && $past(q.phase) != PH_IDLE) |-> $stable(q.chan)); // R2
    AST_MISS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.missed) |-> $past(q.phase) != PH_IDLE); // R9
endmodule

// File: rtl/adc_out_reg.sv
module adc_out_reg #(
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          result_lat,
    input  logic [DW-1:0] code,
    input  logic          rd_rel,
    output logic [DW-1:0] data,
    output logic          irq_n
);
    typedef struct packed {
        logic [DW-1:0] data;
        logic          irq_n;
    } out_t;

    out_t q, d;

    always_comb begin
        d = q;
        if (result_lat) begin
            d.data  = code;
            d.irq_n = 1'b0;
        end else if (rd_rel) begin
            d.irq_n = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{data: '0, irq_n: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign data  = q.data;
    assign irq_n = q.irq_n;

    AST_IRQ_FALL_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.irq_n) |-> $past(result_lat)); // R6
    AST_IRQ_RISE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.irq_n) |-> $past(rd_rel)); // R6
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(result_lat) |-> $stable(q.data)); // R8
endmodule

// File: rtl/adc_bus_ctrl.sv
module adc_bus_ctrl
    import adc_bus_pkg::*;
#(
    parameter int DW         = 10,
    parameter int NUM_CH     = 4,
    parameter int SAMPLE_CYC = 13,
    parameter int COARSE_CYC = 12,
    parameter int FINE_CYC   = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode2,
    input  logic              cs_n,
    input  logic              sh_n,
    input  logic              rd_n,
    input  logic [CHAN_W-1:0] chsel,
    input  logic [DW-1:0]     core_code,
    output logic              core_sample,
    output logic              core_coarse_lat,
    output logic              core_result_lat,
    output logic [CHAN_W-1:0] core_chan,
    output logic [DW-1:0]     dbus_out,
    output logic              dbus_oe,
    output logic              irq_n,
    output logic              missed
);
    localparam int SYNC_W = 3 + CHAN_W;

    typedef struct packed {
        logic sh_act;
        logic rd_act;
    } edge_t;

    logic [SYNC_W-1:0] sync_v;
    logic              cs_s, sh_s, rd_s;
    logic [CHAN_W-1:0] chsel_s, chsel_m;
    logic              sh_act, rd_act, start, rd_rel;
    edge_t             q, d;

    adc_sync2 #(.W(SYNC_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({cs_n, sh_n, rd_n, chsel}),
        .sync_out (sync_v)
    );

    assign {cs_s, sh_s, rd_s, chsel_s} = sync_v;

    generate
        if (NUM_CH >= 4) begin : g_ch4
            assign chsel_m = chsel_s;
        end else if (NUM_CH == 2) begin : g_ch2
            assign chsel_m = {1'b0, chsel_s[0]};
        end else begin : g_ch1
            assign chsel_m = '0;
        end
    endgenerate

    always_comb begin
        sh_act   = !cs_s && !sh_s;
        rd_act   = !cs_s && !rd_s;
        start    = sh_act && !q.sh_act;
        rd_rel   = !rd_act && q.rd_act;
        d.sh_act = sh_act;
        d.rd_act = rd_act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{sh_act: 1'b0, rd_act: 1'b0};
        end else begin
            q <= d;
        end
    end

    adc_conv_fsm #(
        .SAMPLE_CYC (SAMPLE_CYC),
        .COARSE_CYC (COARSE_CYC),
        .FINE_CYC   (FINE_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode2       (mode2),
        .start       (start),
        .sh_act      (sh_act),
        .chsel_m     (chsel_m),
        .core_sample (core_sample),
        .coarse_lat  (core_coarse_lat),
        .result_lat  (core_result_lat),
        .chan        (core_chan),
        .missed      (missed)
    );

    adc_out_reg #(.DW(DW)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .result_lat (core_result_lat),
        .code       (core_code),
        .rd_rel     (rd_rel),
        .data       (dbus_out),
        .irq_n      (irq_n)
    );

    assign dbus_oe = rd_act;

    AST_OE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        dbus_oe |-> (!cs_s && !rd_s)); // R7
    AST_NO_START_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_sample) |-> $past(!cs_s)); // R1
endmodule

// File: tb/sim_adc_bus_ctrl.sv
module sim_adc_bus_ctrl;
    localparam int S = 4;
    localparam int C = 3;
    localparam int F = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode2 = 1'b0;
    logic cs_n = 1'b1, sh_n = 1'b1, rd_n = 1'b1;
    logic [1:0] chsel = 2'd0;
    int   base = 0;
    int   total = 0, bad = 0;
    int   cyc = 0;

    logic [1:0] chan0, chan1;
    logic [9:0] code0, code1, dout0, dout1;
    logic samp0, samp1, clat0, clat1, rlat0, rlat1;
    logic oe0, oe1, irq0, irq1, miss0, miss1;

    always #10 clk = ~clk;

    function automatic logic [9:0] code_of(int b, int ch);
        return 10'((b + 211 * ch) % 1024);
    endfunction

    assign code0 = code_of(base, int'(chan0));
    assign code1 = code_of(base, int'(chan1));

    adc_bus_ctrl #(.NUM_CH(4), .SAMPLE_CYC(S), .COARSE_CYC(C), .FINE_CYC(F)) u0 (
        .clk(clk), .rst_n(rst_n), .mode2(mode2), .cs_n(cs_n), .sh_n(sh_n), .rd_n(rd_n),
        .chsel(chsel), .core_code(code0), .core_sample(samp0), .core_coarse_lat(clat0),
        .core_result_lat(rlat0), .core_chan(chan0), .dbus_out(dout0), .dbus_oe(oe0),
        .irq_n(irq0), .missed(miss0));

    adc_bus_ctrl #(.NUM_CH(2), .SAMPLE_CYC(S), .COARSE_CYC(C), .FINE_CYC(F)) u1 (
        .clk(clk), .rst_n(rst_n), .mode2(mode2), .cs_n(cs_n), .sh_n(sh_n), .rd_n(rd_n),
        .chsel(chsel), .core_code(code1), .core_sample(samp1), .core_coarse_lat(clat1),
        .core_result_lat(rlat1), .core_chan(chan1), .dbus_out(dout1), .dbus_oe(oe1),
        .irq_n(irq1), .missed(miss1));

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_neg(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // mode 1 conversion: sample/hold low for hold_len edges, optional stray pulse
    task automatic conv_m1(int ch, int hold_len, bit stray);
        int n = 0;
        logic [9:0] prev0 = dout0;
        chsel = 2'(ch);
        wait_neg(3);
        sh_n = 1'b0;
        while (irq0 && n < 100) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (n == hold_len) sh_n = 1'b1;
            if (stray && n == 8) sh_n = 1'b0;
            if (stray && n == 9) sh_n = 1'b1;
            if (n == 4) begin
                check("R2 chan captured", int'(chan0), ch);
                check("R3 low bit only", int'(chan1), ch & 1);
            end
            if (irq0) check("R8 data held", int'(dout0), int'(prev0));
        end
        check("R4 mode1 latency", n, ((S > hold_len) ? S : hold_len) + 3 + F);
        check("R8 new code", int'(dout0), int'(code_of(base, ch)));
        check("R3 two-input code", int'(dout1), int'(code_of(base, ch & 1)));
        if (stray) check("R9 missed set", int'(miss0), 1);
        else       check("R9 missed clear", int'(miss0), 0);
        wait_neg(5);
        check("R6 irq stays low", int'(irq0), 0);
        rd_n = 1'b0;
        wait_neg(3);
        check("R7 oe during read", int'(oe0), 1);
        check("R6 irq low in read", int'(irq0), 0);
        rd_n = 1'b1;
        wait_neg(4);
        check("R6 irq released", int'(irq0), 1);
        check("R7 oe released", int'(oe0), 0);
    endtask

    // mode 2 conversion: sample/hold and read tied
    task automatic conv_m2(int ch);
        int n = 0;
        logic [9:0] prev0 = dout0;
        chsel = 2'(ch);
        wait_neg(3);
        sh_n = 1'b0; rd_n = 1'b0;
        while (irq0 && n < 100) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (n == 4) check("R2 chan captured m2", int'(chan0), ch);
            if (irq0) check("R8 previous on bus", int'(dout0), int'(prev0));
            if (n == 6) check("R7 oe in m2", int'(oe0), 1);
        end
        check("R5 mode2 latency", n, 3 + S + C + F);
        check("R8 new code m2", int'(dout0), int'(code_of(base, ch)));
        wait_neg(2);
        sh_n = 1'b1; rd_n = 1'b1;
        wait_neg(4);
        check("R6 irq released m2", int'(irq0), 1);
        check("R7 oe off m2", int'(oe0), 0);
    endtask

    initial begin : watchdog
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        wait_neg(3);
        check("R10 irq reset", int'(irq0), 1);
        check("R10 oe reset", int'(oe0), 0);
        check("R10 data reset", int'(dout0), 0);
        check("R10 missed reset", int'(miss0), 0);
        rst_n = 1'b1;
        wait_neg(2);

        // R1: strobes while deselected
        sh_n = 1'b0; rd_n = 1'b0;
        for (int i = 0; i < 12; i++) begin
            @(posedge clk);
            @(negedge clk);
            check("R1 no sample", int'(samp0), 0);
            check("R1 no oe", int'(oe0), 0);
        end
        check("R1 irq high", int'(irq0), 1);
        sh_n = 1'b1; rd_n = 1'b1;
        wait_neg(4);
        cs_n = 1'b0;
        wait_neg(4);
        check("R1 no start after select", int'(samp0), 0);

        mode2 = 1'b0;
        for (int ch = 0; ch < 4; ch++) begin
            base = 100 + 37 * ch;
            conv_m1(ch, 8, 1'b0);
            base = 500 + 53 * ch;
            conv_m1(ch, 2, 1'b0);
        end
        base = 777;
        conv_m1(2, 2, 1'b1);
        base = 321;
        conv_m1(1, 6, 1'b0);

        mode2 = 1'b1;
        wait_neg(2);
        for (int ch = 0; ch < 4; ch++) begin
            base = 900 - 61 * ch;
            conv_m2(ch);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule